// File: doc/BRIEF.md
# Scatter-Gather Input Fetch Engine

This block pulls data words out of memory and hands them, one beat at a time, to a downstream processing engine over a valid/ready stream. Each beat carries a routing tag whose low field selects the engine that should consume it. A value of zero in that field means the data passes straight through to the output writer.

The engine has two ways of finding its data. In direct mode, a single buffer is described by configuration inputs: address, byte length and tag. In chained mode, the address input points at the first of a linked list of four-word descriptors in memory. Each descriptor names a buffer, its length, its tag and the next descriptor. The word holding the next pointer also carries a stop flag that ends the chain.

Software launches the engine with a start pulse and watches the busy flag. It can end a chain early with a stop request and can abort everything with a soft reset. A one-cycle event marks the end of any block whose descriptor asks for it, and another marks the moment the engine stops.

Top module: `sg_fetch_dma`

## Requirements
- R1: After the reset input is released, and one cycle after a soft_rst pulse, the engine has the following state: busy is 0, out_valid is 0, desc_ptr is 0, and no event is raised.
- R2: A start pulse while idle launches the engine, and busy is 1 from the next cycle. Busy stays 1 until the cycle after evt_stopped. A start pulse while busy is ignored.
- R3: When cfg_indirect is 0 (direct mode), the engine reads ceil(cfg_len/4) words from cfg_addr upward in steps of 4. Each beat carries cfg_tag. The transfer is a single block that raises evt_stopped and never raises evt_block_end.
- R4: When cfg_indirect is 1 (chained mode), a descriptor at address P is read from four words. The word at P is the buffer address. The word at P+4 is the next word: bit 0 is the stop flag, and the next descriptor address is the next word with bits 1:0 cleared. The word at P+8 is the control word: bits 27:0 are the byte length, bit 31 is end-of-block event enable, and bits 30:28 are ignored. The word at P+12 is the tag.
- R5: desc_ptr shows the address of the descriptor most recently taken up. This is cfg_addr at launch in chained mode, then each following next address.
- R6: At the end of each block, evt_block_end pulses for one cycle if the block's event enable is set. If the block's stop flag is set, evt_stopped pulses in the same cycle and the engine goes idle. Otherwise the next descriptor is fetched.
- R7: out_last is 1 on the final beat of every block and 0 on all other beats.
- R8: A block of length 0 produces no beats but still goes through the end-of-block and stop handling of R6.
- R9: A stop_req pulse while busy makes the block in progress the last one. The chain ends when that block completes.
- R10: While out_valid is 1 and out_ready is 0, no memory read is issued and out_data holds its value. Busy stays 1 throughout.
- R11: out_engine equals tag bits 3:0 of the beat's block. out_bypass is 1 exactly when that field is 0, and out_tag carries the whole tag.
- R12: mem_req is a one-cycle pulse, and at most one read is outstanding at any time. A read completes when mem_rvalid returns.
- R13: A soft_rst pulse during a transfer aborts it. No beat or event follows, and a read response that arrives late is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| stop_req | input | 1 | End the chain after the current block |
| soft_rst | input | 1 | Synchronous abort and clear |
| cfg_indirect | input | 1 | 1 selects chained mode, 0 selects direct mode |
| cfg_addr | input | 32 | Buffer address (direct mode) or first descriptor address (chained mode) |
| cfg_len | input | 28 | Byte length in direct mode |
| cfg_tag | input | 32 | Tag in direct mode |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Beat data |
| out_last | output | 1 | Final beat of the block |
| out_tag | output | 32 | Routing tag of the block |
| out_engine | output | 4 | Engine-select field of the tag |
| out_bypass | output | 1 | Engine select is zero (pass-through) |
| busy | output | 1 | Engine active |
| desc_ptr | output | 32 | Current descriptor address |
| evt_block_end | output | 1 | End-of-block event pulse |
| evt_stopped | output | 1 | Stopped event pulse |

## Verification
The assertions watch, on every cycle, the properties that hold locally in time. These are the pulse shape of reads, the silence of the read port during output stalls, the data holding steady during a stall, busy following a launch, idling after a stop or soft reset, and the forced stop flag in direct mode. What only the scenarios can show is the content of a whole transfer. That covers the word addresses walked, the way descriptor fields decode (including the ignored control bits), where last lands, the tag on each beat, the event counts per chain, the desc_ptr value after a chain, the early end caused by a stop request, and the absence of any output after an aborting soft reset.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DREQ,
    S_DWAIT,
    S_SETUP,
    S_RREQ,
    S_RWAIT,
    S_HOLD,
    S_BEND
  } sgf_state_e;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  // descriptor word order and bit positions are decoded by the latch
  localparam logic [IDX_W-1:0] W_BUF  = 2'd0;
  localparam logic [IDX_W-1:0] W_NEXT = 2'd1;
  localparam logic [IDX_W-1:0] W_CTRL = 2'd2;
  localparam logic [IDX_W-1:0] W_TAG  = 2'd3;
  localparam int unsigned STOP_BIT = 0;
  localparam int unsigned IE_BIT   = 31;
endpackage

// File: rtl/sgf_desc_latch.sv
module sgf_desc_latch
  import sgf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 28,
  parameter int unsigned TAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld_direct,
  input  logic              ld_chain,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] rdata,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [TAG_W-1:0]  cfg_tag,
  input  logic              stop_req,
  input  logic              busy,
  output logic [AW-1:0]     blk_addr,
  output logic [LEN_W-1:0]  blk_len,
  output logic [AW-1:0]     next_ptr,
  output logic              blk_ie,
  output logic              blk_stop,
  output logic [TAG_W-1:0]  blk_tag
);
  localparam logic [WORD_W-1:0] PTR_MASK = ~WORD_W'(3);

  logic [AW-1:0]    addr_q, addr_d, next_q, next_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ie_q, ie_d, stop_q, stop_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  always_comb begin
    addr_d = addr_q;
    next_d = next_q;
    len_d  = len_q;
    ie_d   = ie_q;
    stop_d = stop_q;
    tag_d  = tag_q;
    if (clr) begin
      addr_d = '0;
      next_d = '0;
      len_d  = '0;
      ie_d   = 1'b0;
      stop_d = 1'b0;
      tag_d  = '0;
    end else begin
      if (ld_direct) begin
        addr_d = cfg_addr;
        len_d  = cfg_len;
        tag_d  = cfg_tag;
        ie_d   = 1'b0;
        stop_d = 1'b1;
      end else if (ld_chain) begin
        stop_d = 1'b0;
      end
      if (cap_en) begin
        unique case (cap_idx)
          W_BUF:  addr_d = AW'(rdata);
          W_NEXT: begin
            next_d = AW'(rdata & PTR_MASK);
            stop_d = stop_q | rdata[STOP_BIT];
          end
          W_CTRL: begin
            len_d = LEN_W'(rdata);
            ie_d  = rdata[IE_BIT];
          end
          default: tag_d = TAG_W'(rdata);
        endcase
      end
      if (stop_req && busy) stop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      next_q <= '0;
      len_q  <= '0;
      ie_q   <= 1'b0;
      stop_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      addr_q <= addr_d;
      next_q <= next_d;
      len_q  <= len_d;
      ie_q   <= ie_d;
      stop_q <= stop_d;
      tag_q  <= tag_d;
    end
  end

  assign blk_addr = addr_q;
  assign blk_len  = len_q;
  assign next_ptr = next_q;
  assign blk_ie   = ie_q;
  assign blk_stop = stop_q;
  assign blk_tag  = tag_q;

  AST_DIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_direct && !clr) |=> (blk_stop && !blk_ie)); // R3
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && busy && !clr) |=> blk_stop); // R9
endmodule

// File: rtl/sgf_out_stage.sv
module sgf_out_stage
  import sgf_pkg::*;
#(
  parameter int unsigned TAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              last_in,
  input  logic [WORD_W-1:0] data_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              last,
  output logic [TAG_W-1:0]  tag,
  output logic              taken
);
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] data_q;
  logic              last_q;
  logic [TAG_W-1:0]  tag_q;
  logic              cap;

  assign taken = valid_q && ready;
  assign cap   = load && !clr;

  always_comb begin
    valid_d = valid_q;
    if (clr)        valid_d = 1'b0;
    else if (load)  valid_d = 1'b1;
    else if (taken) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (cap) begin
        data_q <= data_in;
        last_q <= last_in;
        tag_q  <= tag_in;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign last  = last_q;
  assign tag   = tag_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !clr) |=> (valid && $stable(data) && $stable(last))); // R10
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid); // R10
endmodule

// File: rtl/sgf_ctrl.sv
module sgf_ctrl
  import sgf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic             cfg_indirect,
  input  logic [AW-1:0]    cfg_addr,
  input  logic             mem_rvalid,
  input  logic [AW-1:0]    blk_addr,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [AW-1:0]    next_ptr,
  input  logic             blk_ie,
  input  logic             blk_stop,
  input  logic             beat_taken,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             ld_direct,
  output logic             ld_chain,
  output logic             beat_load,
  output logic             beat_last,
  output logic             busy,
  output logic [AW-1:0]    desc_ptr,
  output logic             evt_block_end,
  output logic             evt_stopped
);
  localparam int unsigned CNT_W = LEN_W - 1;

  sgf_state_e       state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic [AW-1:0]    rd_q, rd_d, dptr_q, dptr_d;
  logic [CNT_W-1:0] words_q, words_d;
  logic [LEN_W:0]   len_rnd;
  logic [CNT_W-1:0] blk_words;

  assign len_rnd   = {1'b0, blk_len} + (LEN_W + 1)'(WORD_BYTES - 1);
  assign blk_words = len_rnd[LEN_W:2];

  always_comb begin
    state_d   = state_q;
    widx_d    = widx_q;
    rd_d      = rd_q;
    words_d   = words_q;
    dptr_d    = dptr_q;
    cap_en    = 1'b0;
    ld_direct = 1'b0;
    ld_chain  = 1'b0;
    beat_load = 1'b0;
    if (soft_rst) begin
      state_d = S_IDLE;
      widx_d  = '0;
      rd_d    = '0;
      words_d = '0;
      dptr_d  = '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          if (cfg_indirect) begin
            ld_chain = 1'b1;
            dptr_d   = cfg_addr;
            widx_d   = '0;
            state_d  = S_DREQ;
          end else begin
            ld_direct = 1'b1;
            state_d   = S_SETUP;
          end
        end
        S_DREQ:  state_d = S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          cap_en = 1'b1;
          if (widx_q == W_TAG) state_d = S_SETUP;
          else begin
            widx_d  = IDX_W'(widx_q + 1'b1);
            state_d = S_DREQ;
          end
        end
        S_SETUP: begin
          rd_d    = blk_addr;
          words_d = blk_words;
          state_d = (blk_words == '0) ? S_BEND : S_RREQ;
        end
        S_RREQ:  state_d = S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          beat_load = 1'b1;
          rd_d      = rd_q + AW'(WORD_BYTES);
          words_d   = words_q - CNT_W'(1);
          state_d   = S_HOLD;
        end
        S_HOLD: if (beat_taken) state_d = (words_q == '0) ? S_BEND : S_RREQ;
        S_BEND: begin
          if (blk_stop) state_d = S_IDLE;
          else begin
            dptr_d  = next_ptr;
            widx_d  = '0;
            state_d = S_DREQ;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      rd_q    <= '0;
      words_q <= '0;
      dptr_q  <= '0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      rd_q    <= rd_d;
      words_q <= words_d;
      dptr_q  <= dptr_d;
    end
  end

  assign mem_req       = (state_q == S_DREQ) || (state_q == S_RREQ);
  assign mem_addr      = (state_q == S_DREQ) ? dptr_q + AW'({widx_q, 2'b00}) : rd_q;
  assign cap_idx       = widx_q;
  assign beat_last     = (words_q == CNT_W'(1));
  assign busy          = (state_q != S_IDLE);
  assign desc_ptr      = dptr_q;
  assign evt_block_end = (state_q == S_BEND) && blk_ie;
  assign evt_stopped   = (state_q == S_BEND) && blk_stop;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R12
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !soft_rst) |=> busy); // R2
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stopped |=> !busy); // R6
  AST_SOFT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && desc_ptr == '0)); // R13
endmodule

// File: rtl/sg_fetch_dma.sv
module sg_fetch_dma
  import sgf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 28,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned ENG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop_req,
  input  logic              soft_rst,
  input  logic              cfg_indirect,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [TAG_W-1:0]  cfg_tag,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ENG_W-1:0]  out_engine,
  output logic              out_bypass,
  output logic              busy,
  output logic [AW-1:0]     desc_ptr,
  output logic              evt_block_end,
  output logic              evt_stopped
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic             cap_en, ld_direct, ld_chain, beat_load, beat_last, beat_taken;
  logic [IDX_W-1:0] cap_idx;
  logic [AW-1:0]    blk_addr, next_ptr;
  logic [LEN_W-1:0] blk_len;
  logic             blk_ie, blk_stop;
  logic [TAG_W-1:0] blk_tag;

  sgf_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .soft_rst(soft_rst), .start(start),
    .cfg_indirect(cfg_indirect), .cfg_addr(cfg_addr), .mem_rvalid(mem_rvalid),
    .blk_addr(blk_addr), .blk_len(blk_len), .next_ptr(next_ptr),
    .blk_ie(blk_ie), .blk_stop(blk_stop), .beat_taken(beat_taken),
    .mem_req(mem_req), .mem_addr(mem_addr), .cap_en(cap_en), .cap_idx(cap_idx),
    .ld_direct(ld_direct), .ld_chain(ld_chain), .beat_load(beat_load),
    .beat_last(beat_last), .busy(busy), .desc_ptr(desc_ptr),
    .evt_block_end(evt_block_end), .evt_stopped(evt_stopped)
  );

  sgf_desc_latch #(.AW(AW), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_desc (
    .clk(clk), .rst_n(rst_int_n), .clr(soft_rst), .ld_direct(ld_direct),
    .ld_chain(ld_chain), .cap_en(cap_en), .cap_idx(cap_idx), .rdata(mem_rdata),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_tag(cfg_tag),
    .stop_req(stop_req), .busy(busy), .blk_addr(blk_addr), .blk_len(blk_len),
    .next_ptr(next_ptr), .blk_ie(blk_ie), .blk_stop(blk_stop), .blk_tag(blk_tag)
  );

  sgf_out_stage #(.TAG_W(TAG_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .clr(soft_rst), .load(beat_load),
    .last_in(beat_last), .data_in(mem_rdata), .tag_in(blk_tag),
    .ready(out_ready), .valid(out_valid), .data(out_data), .last(out_last),
    .tag(out_tag), .taken(beat_taken)
  );

  assign out_engine = out_tag[ENG_W-1:0];
  assign out_bypass = (out_engine == '0);

  AST_NO_READ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |-> (!mem_req && busy)); // R10
  AST_EVENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (evt_block_end || evt_stopped) |-> busy); // R6
endmodule

// File: tb/sg_fetch_dma_bench.sv
module sg_fetch_dma_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, stop_req, soft_rst, cfg_indirect;
  logic [31:0] cfg_addr;
  logic [27:0] cfg_len;
  logic [31:0] cfg_tag;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        out_valid, out_ready, out_last, out_bypass;
  logic [31:0] out_data, out_tag, desc_ptr;
  logic [3:0]  out_engine;
  logic        busy, evt_block_end, evt_stopped;

  sg_fetch_dma u_sg_fetch_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .soft_rst(soft_rst), .cfg_indirect(cfg_indirect), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .cfg_tag(cfg_tag), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_tag(out_tag), .out_engine(out_engine),
    .out_bypass(out_bypass), .busy(busy), .desc_ptr(desc_ptr),
    .evt_block_end(evt_block_end), .evt_stopped(evt_stopped)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // memory model: two-cycle read latency
  logic [31:0] mem [0:127];
  logic        rv1;
  logic [31:0] a1;
  always @(posedge clk) begin
    if (!rst_n) begin
      rv1 <= 1'b0; a1 <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      rv1 <= mem_req; a1 <= mem_addr;
      mem_rvalid <= rv1; mem_rdata <= mem[a1[8:2]];
    end
  end

  // ready pattern: 0 always, 1 one in three, 2 never
  int rmode = 0, rcnt = 0;
  always begin
    @(posedge clk); #2;
    rcnt++;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = (rcnt % 3 == 0);
      default: out_ready = 1'b0;
    endcase
  end

  // monitor
  int nbeat = 0, be_cnt = 0, st_cnt = 0, stall_reads = 0, unstable = 0, multi = 0, outst = 0;
  logic [31:0] bdata [0:63];
  logic [31:0] btag [0:63];
  bit blast [0:63];
  bit bbyp [0:63];
  logic [3:0] beng [0:63];
  bit prev_stall = 0;
  logic [31:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rvalid && outst > 0) outst--;
      if (mem_req) begin
        if (outst != 0) multi++;
        outst++;
      end
      if (out_valid && out_ready && nbeat < 64) begin
        bdata[nbeat] = out_data; blast[nbeat] = out_last; btag[nbeat] = out_tag;
        beng[nbeat] = out_engine; bbyp[nbeat] = out_bypass;
        nbeat++;
      end
      if (out_valid && !out_ready && mem_req) stall_reads++;
      if (prev_stall && out_valid && out_data != prev_data) unstable++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (evt_block_end) be_cnt++;
      if (evt_stopped) st_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    nbeat = 0; be_cnt = 0; st_cnt = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] bufa,
                          input logic [31:0] nxt, input logic [31:0] ctl, input logic [31:0] tg);
    mem[base[8:2]]      = bufa;
    mem[base[8:2] + 1]  = nxt;
    mem[base[8:2] + 2]  = ctl;
    mem[base[8:2] + 3]  = tg;
  endtask

  task automatic launch();
    start = 1'b1; tick(1); start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
    tick(0);
  endtask

  task automatic wait_stop();
    for (int n = 0; n < 600 && st_cnt == 0; n++) tick(1);
    tick(3);
  endtask

  task automatic chk_beat(input int i, input logic [31:0] addr, input bit lst,
                          input logic [31:0] tg, input string req);
    chk(bdata[i] === mem[addr[8:2]], req, bdata[i], mem[addr[8:2]]);
    chk(blast[i] === lst, "R7 last flag", {31'd0, blast[i]}, {31'd0, lst});
    chk(btag[i] === tg, "R11 tag on beat", btag[i], tg);
    chk(beng[i] === tg[3:0], "R11 engine field", {28'd0, beng[i]}, {28'd0, tg[3:0]});
    chk(bbyp[i] === (tg[3:0] == 4'd0), "R11 bypass flag", {31'd0, bbyp[i]}, {31'd0, tg[3:0] == 4'd0});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", {31'd0, busy}, 0);
    chk(out_valid === 1'b0, "R1 valid after reset", {31'd0, out_valid}, 0);
    chk(desc_ptr === 32'd0, "R1 desc_ptr after reset", desc_ptr, 0);
    chk(evt_block_end === 1'b0 && evt_stopped === 1'b0, "R1 no events", {30'd0, evt_block_end, evt_stopped}, 0);
    tick(0);
  endtask

  task automatic t_direct();
    clear_mon();
    cfg_indirect = 1'b0; cfg_addr = 32'h100; cfg_len = 28'd10; cfg_tag = 32'h0000_0001;
    launch();
    wait_stop();
    chk(nbeat == 3, "R3 direct beat count", nbeat, 3);
    chk_beat(0, 32'h100, 0, 32'h1, "R3 direct word 0");
    chk_beat(1, 32'h104, 0, 32'h1, "R3 direct word 1");
    chk_beat(2, 32'h108, 1, 32'h1, "R3 direct word 2");
    chk(be_cnt == 0, "R3 no block event in direct", be_cnt, 0);
    chk(st_cnt == 1, "R3 stopped once", st_cnt, 1);
    chk(busy === 1'b0, "R2 idle after stop", {31'd0, busy}, 0);
  endtask

  task automatic t_chain();
    clear_mon();
    // control bits 30:28 set to show they are ignored
    put_desc(32'h000, 32'h100, 32'h010, 32'hF000_0008, 32'h0000_0050);
    put_desc(32'h010, 32'h140, 32'h0000_0023, 32'h0000_0004, 32'h0000_0002);
    cfg_indirect = 1'b1; cfg_addr = 32'h000;
    launch();
    wait_stop();
    chk(nbeat == 3, "R4 chain beat count", nbeat, 3);
    chk_beat(0, 32'h100, 0, 32'h50, "R4 chain block0 word0");
    chk_beat(1, 32'h104, 1, 32'h50, "R4 chain block0 word1");
    chk_beat(2, 32'h140, 1, 32'h02, "R4 chain block1 word0");
    chk(be_cnt == 1, "R6 block event only when enabled", be_cnt, 1);
    chk(st_cnt == 1, "R6 stopped once", st_cnt, 1);
    chk(desc_ptr === 32'h010, "R5 desc_ptr follows chain", desc_ptr, 32'h010);
  endtask

  task automatic t_zero();
    clear_mon();
    put_desc(32'h020, 32'h100, 32'h0000_0001, 32'h8000_0000, 32'h1);
    cfg_indirect = 1'b1; cfg_addr = 32'h020;
    launch();
    wait_stop();
    chk(nbeat == 0, "R8 zero length no beats", nbeat, 0);
    chk(be_cnt == 1, "R8 zero length block event", be_cnt, 1);
    chk(st_cnt == 1, "R8 zero length stopped", st_cnt, 1);
    chk(desc_ptr === 32'h020, "R5 desc_ptr first descriptor", desc_ptr, 32'h020);
  endtask

  task automatic t_stopreq();
    clear_mon();
    put_desc(32'h030, 32'h180, 32'h040, 32'h0000_0010, 32'h1);
    put_desc(32'h040, 32'h1C0, 32'h0000_0001, 32'h8000_0004, 32'h1);
    cfg_indirect = 1'b1; cfg_addr = 32'h030;
    launch();
    for (int n = 0; n < 100 && nbeat == 0; n++) tick(1);
    stop_req = 1'b1; tick(1); stop_req = 1'b0;
    cfg_indirect = 1'b0; cfg_addr = 32'h100; cfg_len = 28'd4;
    start = 1'b1; tick(1); start = 1'b0;   // ignored while busy
    wait_stop();
    chk(nbeat == 4, "R9 chain ends after current block", nbeat, 4);
    chk_beat(3, 32'h18C, 1, 32'h1, "R2 restart ignored while busy");
    chk(be_cnt == 0, "R9 second block never ran", be_cnt, 0);
    chk(st_cnt == 1, "R9 stopped once", st_cnt, 1);
    chk(desc_ptr === 32'h030, "R9 desc_ptr unchanged", desc_ptr, 32'h030);
  endtask

  task automatic t_backpressure();
    clear_mon();
    rmode = 1;
    cfg_indirect = 1'b0; cfg_addr = 32'h120; cfg_len = 28'd16; cfg_tag = 32'h0000_0003;
    launch();
    wait_stop();
    rmode = 0;
    chk(nbeat == 4, "R10 beats under stall", nbeat, 4);
    for (int i = 0; i < 4; i++)
      chk_beat(i, 32'h120 + 32'(4 * i), i == 3, 32'h3, "R10 data under stall");
    chk(stall_reads == 0, "R10 no read during stall", stall_reads, 0);
    chk(unstable == 0, "R10 data held during stall", unstable, 0);
  endtask

  task automatic t_soft();
    clear_mon();
    rmode = 2;
    cfg_indirect = 1'b0; cfg_addr = 32'h100; cfg_len = 28'd32; cfg_tag = 32'h1;
    launch();
    for (int n = 0; n < 50 && !out_valid; n++) tick(1);
    tick(2);
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R13 soft reset idles", {31'd0, busy}, 0);
    chk(out_valid === 1'b0, "R1 soft reset drops beat", {31'd0, out_valid}, 0);
    tick(0);
    rmode = 0;
    tick(20);
    chk(nbeat == 0, "R13 no beats after abort", nbeat, 0);
    chk(st_cnt == 0 && be_cnt == 0, "R13 no events after abort", st_cnt + be_cnt, 0);
    chk(desc_ptr === 32'd0, "R1 desc_ptr cleared by soft reset", desc_ptr, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h0001_0101);
    rst_n = 1'b0; start = 1'b0; stop_req = 1'b0; soft_rst = 1'b0;
    cfg_indirect = 1'b0; cfg_addr = '0; cfg_len = '0; cfg_tag = '0; out_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_direct();
    t_chain();
    t_zero();
    t_stopreq();
    t_backpressure();
    t_soft();
    chk(multi == 0, "R12 single outstanding read", multi, 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule